// File: doc/BRIEF.md
# Armed Interrupt Request Controller

This block gathers service requests from a few peripherals and turns them into a single interrupt request for a processor core, along with a vector number. There are two kinds of request input.

- **Dedicated lines.** Each dedicated line is edge-triggered. A rising edge, which marks a device moving from busy to done, sets that line's own pending flag. Each dedicated line has its own vector.
- **Shared line.** One shared line is active-low and level-sensitive. Any number of open-drain devices may pull it to 0, and it idles high. All devices on the shared line use one common vector. The handler must ask the devices themselves which one needs service.

Every source has an arm bit, and a global enable sits above all of them. Turning the global enable off holds pending requests rather than dropping them. A small register port lets software:

- set the enable,
- set the arm mask,
- read the pending status and the presented vector,
- clear dedicated flags by writing ones to the status register.

A processor acknowledge that carries a vector also clears the matching dedicated flag.

Every external request input passes through a two-flop synchronizer before it is used. Requests are presented in fixed priority. The lowest-numbered dedicated line wins. The shared line ranks below every dedicated line.

Top module: `armed_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0 and `vec_out` is 0. The control, arm and status registers all read as 0.
- R2: A source whose arm bit is 0 never causes `irq_out` to rise, even while its pending flag is set.
- R3: While the global enable (bit 0 of register 0) is 0, `irq_out` is 0 from the next cycle on.
- R4: Clearing the global enable keeps pending flags set. When the enable is set again, the request returns.
- R5: A rising edge on `ded_irq[i]` sets status bit i of register 2. The bit can be read 3 cycles after the input rises (two synchronizer flops plus the edge register).
- R6: Register 2 bit N_DED reads 1 while the shared line is held low, 2 cycles after the line falls. An acknowledge does not clear it. It clears only when the line returns high.
- R7: Dedicated line i presents vector VEC_BASE+i. The shared line presents VEC_BASE+N_DED.
- R8: Among armed pending sources, the lowest-numbered dedicated line is presented first. The shared line is presented only when no dedicated line is armed and pending.
- R9: Writing register 2 clears each dedicated flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R10: When `ack` is high and `ack_vec` equals VEC_BASE+i, dedicated flag i is cleared.
- R11: `irq_out` equals, one cycle later, the global enable ANDed with the OR over all sources of (pending AND armed). `vec_out` is 0 whenever `irq_out` is 0. Register 3 reads `vec_out`.
- R12: If a dedicated edge arrives in the same cycle as a clear for that line, the flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shr_irq_n | input | 1 | Shared level request, active low |
| ded_irq | input | N_DED | Dedicated edge-triggered requests |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 arm, 2 status, 3 vector |
| wdata | input | N_DED+1 | Write data |
| rdata | output | VW | Read data for `addr` |
| ack | input | 1 | Processor acknowledge |
| ack_vec | input | VW | Vector being acknowledged |
| irq_out | output | 1 | Registered interrupt request |
| vec_out | output | VW | Vector of the presented source |

## Verification
The bench builds the block with N_DED=4, VW=8 and VEC_BASE=32. With these values the five arm and status bits fit inside the 8-bit read port. This gives a four-way priority chain among the dedicated lines, with the shared line below all four. Vectors 32 to 36 are all distinct, so an acknowledge aimed at the wrong line shows up as a status mismatch. Directed sequences cover the following:
- an edge and a clear landing in the same cycle;
- an acknowledge sent to the shared vector;
- toggling the enable while requests are pending.

A long random phase then compares every output against the behavioural model on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_ARM  = 2'd1,
        REG_STAT = 2'd2,
        REG_VEC  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } edge_st_t;

    edge_st_t     st_d, st_q;
    logic [N-1:0] rise;

    always_comb begin
        st_d      = st_q;
        rise      = lvl & ~st_q.prev;
        st_d.prev = lvl;
        st_d.pend = (st_q.pend & ~clr) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    // R5
    set_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend & $past(rise)) == $past(rise)));

    // R9
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~rise)) |=> ((pend & $past(clr & ~rise)) == '0));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N-1:0] gnt;

    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                any    = 1'b1;
                idx    = IW'(i);
                gnt[i] = 1'b1;
            end
        end
        // R8
        single_grant_chk: assert ($onehot0(gnt));
    end
endmodule

// File: rtl/armed_irq_ctrl.sv
module armed_irq_ctrl
    import irq_pkg::*;
#(
    parameter int N_DED    = 4,
    parameter int VW       = 8,
    parameter int VEC_BASE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shr_irq_n,
    input  logic [N_DED-1:0] ded_irq,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [N_DED:0]   wdata,
    output logic [VW-1:0]    rdata,
    input  logic             ack,
    input  logic [VW-1:0]    ack_vec,
    output logic             irq_out,
    output logic [VW-1:0]    vec_out
);
    localparam int NS = N_DED + 1;
    localparam int IW = (NS > 1) ? $clog2(NS) : 1;

    typedef struct packed {
        logic          en;
        logic [NS-1:0] arm;
        logic          irq;
        logic [VW-1:0] vec;
    } ctl_st_t;

    ctl_st_t          st_d, st_q;
    logic [N_DED-1:0] ded_s, ded_clr, ded_pend;
    logic             shr_s;
    logic [NS-1:0]    src_pend, src_req;
    logic [IW-1:0]    win_idx;
    logic             win_any;
    logic             stat_wr;

    irq_sync #(.W(N_DED), .RST_VAL('0)) u_sync_ded (
        .clk(clk), .rst_n(rst_n), .din(ded_irq), .dout(ded_s));

    irq_sync #(.W(1), .RST_VAL(1'b1)) u_sync_shr (
        .clk(clk), .rst_n(rst_n), .din(shr_irq_n), .dout(shr_s));

    assign stat_wr = wr_en && (reg_addr_e'(addr) == REG_STAT);

    for (genvar i = 0; i < N_DED; i++) begin : g_clr
        assign ded_clr[i] = (stat_wr && wdata[i])
                          || (ack && (ack_vec == VW'(VEC_BASE + i)));
    end

    irq_edge_pend #(.N(N_DED)) u_pend (
        .clk(clk), .rst_n(rst_n), .lvl(ded_s), .clr(ded_clr), .pend(ded_pend));

    assign src_pend = {~shr_s, ded_pend};
    assign src_req  = src_pend & st_q.arm;

    irq_prio #(.N(NS), .IW(IW)) u_prio (
        .req(src_req), .idx(win_idx), .any(win_any));

    always_comb begin
        st_d     = st_q;
        st_d.irq = st_q.en && win_any;
        st_d.vec = (st_q.en && win_any) ? (VW'(VEC_BASE) + VW'(win_idx)) : '0;
        if (wr_en) begin
            case (reg_addr_e'(addr))
                REG_CTRL: st_d.en  = wdata[0];
                REG_ARM:  st_d.arm = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            REG_CTRL: rdata = VW'(st_q.en);
            REG_ARM:  rdata = VW'(st_q.arm);
            REG_STAT: rdata = VW'(src_pend);
            default:  rdata = st_q.vec;
        endcase
    end

    assign irq_out = st_q.irq;
    assign vec_out = st_q.vec;

    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |=> !irq_out);

    // R7
    vec_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (vec_out >= VW'(VEC_BASE) && vec_out <= VW'(VEC_BASE + N_DED)));

    // R11
    idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> (vec_out == '0));
endmodule

// File: tb/tb_armed_irq_ctrl.sv
module tb_armed_irq_ctrl;
    localparam int ND = 4;
    localparam int VB = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shr_irq_n = 1'b1;
    logic [3:0] ded_irq = '0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [4:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic [7:0] ack_vec = '0;
    logic       irq_out;
    logic [7:0] vec_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit auto_on  = 1'b0;

    always #4 clk = ~clk;

    armed_irq_ctrl #(.N_DED(ND), .VW(8), .VEC_BASE(VB)) dut (
        .clk(clk), .rst_n(rst_n), .shr_irq_n(shr_irq_n), .ded_irq(ded_irq),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ack(ack), .ack_vec(ack_vec), .irq_out(irq_out), .vec_out(vec_out));

    // behavioural reference model
    logic [3:0] m_q1, m_q2, m_prev, m_pend;
    logic       m_sh1, m_sh2;
    logic       m_en;
    logic [4:0] m_arm;
    logic       m_irq;
    logic [7:0] m_vec;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q1 <= '0; m_q2 <= '0; m_prev <= '0; m_pend <= '0;
            m_sh1 <= 1'b1; m_sh2 <= 1'b1;
            m_en <= 1'b0; m_arm <= '0; m_irq <= 1'b0; m_vec <= '0;
        end else begin : step
            logic [3:0] edges;
            logic [3:0] kill;
            logic [4:0] want;
            int         first;
            edges = m_q2 & ~m_prev;
            kill  = '0;
            if (wr_en && addr == 2'd2) kill = wdata[3:0];
            if (ack) begin
                for (int i = 0; i < ND; i++) if (ack_vec == 8'(VB + i)) kill[i] = 1'b1;
            end
            want  = {~m_sh2, m_pend} & m_arm;
            first = -1;
            for (int i = 4; i >= 0; i--) if (want[i]) first = i;
            m_irq  <= m_en && (first >= 0);
            m_vec  <= (m_en && first >= 0) ? 8'(VB + first) : 8'd0;
            m_pend <= (m_pend & ~kill) | edges;
            if (wr_en && addr == 2'd0) m_en  <= wdata[0];
            if (wr_en && addr == 2'd1) m_arm <= wdata;
            m_prev <= m_q2; m_q2 <= m_q1; m_q1 <= ded_irq;
            m_sh2 <= m_sh1; m_sh1 <= shr_irq_n;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {7'd0, m_en};
            2'd1:    return {3'd0, m_arm};
            2'd2:    return {3'd0, ~m_sh2, m_pend};
            default: return m_vec;
        endcase
    endfunction

    always @(negedge clk) begin
        #3;
        if (auto_on && rst_n) begin
            chk("R11 irq vs model", irq_out, m_irq);
            chk("R8 vec vs model", vec_out, m_vec);
            chk("R9 rdata vs model", rdata, model_rd(addr));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [4:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
        @(negedge clk);
        addr = a;
        #3;
        chk(tag, rdata, exp);
    endtask

    task automatic do_ack(input logic [7:0] v);
        @(negedge clk);
        ack = 1'b1; ack_vec = v;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        auto_on = 1'b1;
        // R1 reset state
        chk("R1 irq", irq_out, 0);
        chk("R1 vec", vec_out, 0);
        rd_chk("R1 ctrl", 2'd0, 0);
        rd_chk("R1 arm", 2'd1, 0);
        rd_chk("R1 stat", 2'd2, 0);

        // R5 edge capture while disabled, R3 quiet
        wr(2'd1, 5'h1F);
        ded_irq = 4'b0010; idle(5); ded_irq = '0;
        rd_chk("R5 stat", 2'd2, 8'h02);
        chk("R3 irq disabled", irq_out, 0);

        // R11 / R7 enable
        wr(2'd0, 5'h01); idle(2);
        chk("R11 irq", irq_out, 1);
        chk("R7 vec ded1", vec_out, VB + 1);

        // R8 priority
        ded_irq = 4'b0101; idle(5); ded_irq = '0;
        chk("R8 lowest first", vec_out, VB);

        // R9 write of zeros, then one
        wr(2'd2, 5'h00); idle(2);
        rd_chk("R9 zeros keep", 2'd2, 8'h07);
        wr(2'd2, 5'h01); idle(2);
        chk("R9 w1c vec", vec_out, VB + 1);
        rd_chk("R9 w1c stat", 2'd2, 8'h06);

        // R10 acknowledge
        do_ack(8'(VB + 1)); idle(2);
        rd_chk("R10 ack clear", 2'd2, 8'h04);
        chk("R10 next vec", vec_out, VB + 2);

        // R4 enable off keeps pending
        wr(2'd0, 5'h00); idle(2);
        chk("R4 irq off", irq_out, 0);
        rd_chk("R4 held", 2'd2, 8'h04);
        wr(2'd0, 5'h01); idle(2);
        chk("R4 irq back", irq_out, 1);
        chk("R4 vec back", vec_out, VB + 2);
        wr(2'd2, 5'h04); idle(2);
        chk("R9 all clear", irq_out, 0);

        // R2 unarmed source
        wr(2'd1, 5'h17);
        ded_irq = 4'b1000; idle(5); ded_irq = '0; idle(2);
        rd_chk("R2 pend set", 2'd2, 8'h08);
        chk("R2 irq low", irq_out, 0);
        wr(2'd2, 5'h08);

        // R6 shared line
        shr_irq_n = 1'b0; idle(4);
        chk("R6 irq", irq_out, 1);
        chk("R7 shared vec", vec_out, VB + ND);
        rd_chk("R6 stat", 2'd2, 8'h10);
        do_ack(8'(VB + ND)); idle(3);
        rd_chk("R6 ack no clear", 2'd2, 8'h10);
        chk("R6 irq held", irq_out, 1);
        ded_irq = 4'b0001; idle(5); ded_irq = '0;
        chk("R8 ded over shared", vec_out, VB);
        wr(2'd2, 5'h01); idle(2);
        chk("R8 shared after", vec_out, VB + ND);
        shr_irq_n = 1'b1; idle(4);
        rd_chk("R6 release", 2'd2, 0);
        chk("R6 irq gone", irq_out, 0);

        // R12 edge and clear in same cycle
        @(negedge clk); ded_irq = 4'b0010;
        @(negedge clk);
        wr(2'd2, 5'h02);
        rd_chk("R12 set wins", 2'd2, 8'h02);
        ded_irq = '0;
        wr(2'd2, 5'h02); idle(2);
        rd_chk("R12 later clear", 2'd2, 0);

        // random phase against the model
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            ded_irq   = 4'($urandom);
            shr_irq_n = ($urandom % 4) != 0;
            wr_en     = ($urandom % 3) == 0;
            addr      = 2'($urandom);
            wdata     = 5'($urandom);
            ack       = ($urandom % 4) == 0;
            ack_vec   = 8'(VB + ($urandom % 6));
        end
        @(negedge clk);
        wr_en = 1'b0; ack = 1'b0;
        idle(3);
        finish_run();
    end
endmodule